// File: doc/BRIEF.md
# Bidirectional DES Round-Key Generator

This block produces the sixteen 48-bit round keys of the DES cipher one at a time, from a 64-bit key, as a cipher core consumes them. A load pulse captures the key. The key is reduced to 56 bits by the fixed first key selection, and the 8 byte-parity bits are discarded. The 56 bits are held as two 28-bit halves. Each step pulse produces the next round key by rotating both halves and passing them through the fixed 56-to-48 compression selection.

The key direction is captured with the load. In forward (encryption) order the halves rotate left before each selection, and the round keys come out first to sixteenth. In reverse (decryption) order the round keys are selected first and the halves then rotate right, so the keys come out sixteenth to first. No key table is stored. After sixteen steps the halves are back at their loaded value. A done flag shows that the whole schedule has been produced.

Top module: `des_keygen`

## Requirements
- R1: A load captures the key, and the parity bits are dropped by the standard 64-to-56 key selection. With key 0x133457799BBCDFF1 in forward order, the first step yields round key 0x1B02EFFC7072. In the 48-bit output, bit 47 holds the first selected bit.
- R2: When loaded with direction input low (forward), successive steps yield round keys 1 through 16 in order. Before the selection of round r, the halves are rotated left by 1 place for r = 1, 2, 9 and 16, and by 2 places for every other round.
- R3: When loaded with direction input high (reverse), successive steps yield round keys 16 down to 1. Each key equals the forward key of the same index.
- R4: `subKey` takes its new value on the clock edge that samples the step pulse. It holds its value in every cycle with neither a load nor a step.
- R5: `keyDone` is low from a load until the sixteenth accepted step. It is high from the edge that samples that step on.
- R6: A step pulse while `keyDone` is high is ignored: `subKey` and `keyDone` are unchanged.
- R7: A load clears `subKey` to zero and `keyDone` to low, and restarts the schedule. When a load and a step arrive in the same cycle, the load wins and the step is dropped.
- R8: The direction is sampled only with the load. Changing `dirIn` between loads does not alter the order of the keys.
- R9: Keys that differ only in bits 0, 8, 16, 24, 32, 40, 48 and 56 (the byte parity bits) produce identical round keys.
- R10: After reset, `subKey` is zero and `keyDone` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadKey | input | 1 | Capture `keyIn` and `dirIn`, restart the schedule |
| stepKey | input | 1 | Produce the next round key |
| dirIn | input | 1 | 0 forward (encryption) order, 1 reverse (decryption) order |
| keyIn | input | 64 | Cipher key including parity bits |
| subKey | output | 48 | Current round key |
| keyDone | output | 1 | All sixteen round keys have been produced |

## Verification
The schedule is tried with a published test key whose first round key is known, and with several other keys, in both directions. This separates a correct selection table and rotation schedule from a wrong one, and a reverse walk from one that merely replays forward keys. A key with every parity bit flipped shows whether those bits leak into the output. Toggling `dirIn` in mid-schedule, stepping past the end, stepping with gaps, and a load coinciding with a step expose latching, saturation and priority faults.

// File: rtl/des_keygen_pkg.sv
package des_keygen_pkg;
  localparam int KEY_W   = 64;
  localparam int CD_W    = 56;
  localparam int HALF_W  = CD_W / 2;
  localparam int SUB_W   = 48;
  localparam int ROUNDS  = 16;
  localparam int CNT_W   = $clog2(ROUNDS + 1);

  typedef struct packed {
    logic load;
    logic advance;
    logic reverse;
    logic twoPlaces;
  } keyCtl_t;

  localparam int SEL56 [CD_W] = '{
    57,49,41,33,25,17,9,1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,19,11,3,60,52,44,36,
    63,55,47,39,31,23,15,7,62,54,46,38,30,22,
    14,6,61,53,45,37,29,21,13,5,28,20,12,4};

  localparam int SEL48 [SUB_W] = '{
    14,17,11,24,1,5,3,28,15,6,21,10,
    23,19,12,4,26,8,16,7,27,20,13,2,
    41,52,31,37,47,55,30,40,51,45,33,48,
    44,49,39,56,34,53,46,42,50,36,29,32};

  function automatic logic [CD_W-1:0] reduceKey(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] o;
    for (int i = 0; i < CD_W; i++) o[CD_W-1-i] = k[KEY_W-SEL56[i]];
    return o;
  endfunction

  function automatic logic [SUB_W-1:0] compressKey(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] o;
    for (int i = 0; i < SUB_W; i++) o[SUB_W-1-i] = cd[CD_W-SEL48[i]];
    return o;
  endfunction

  function automatic logic [HALF_W-1:0] rotHalf(input logic [HALF_W-1:0] h,
                                                input logic two, input logic right);
    logic [HALF_W-1:0] o;
    if (right) o = two ? {h[1:0], h[HALF_W-1:2]} : {h[0], h[HALF_W-1:1]};
    else       o = two ? {h[HALF_W-3:0], h[HALF_W-1:HALF_W-2]}
                       : {h[HALF_W-2:0], h[HALF_W-1]};
    return o;
  endfunction

  function automatic logic singleShift(input int unsigned r);
    return (r == 1) || (r == 2) || (r == 9) || (r == ROUNDS);
  endfunction
endpackage

// File: rtl/des_keygen_ctrl.sv
module des_keygen_ctrl
  import des_keygen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    loadKey,
  input  logic    stepKey,
  input  logic    dirIn,
  output keyCtl_t ctl,
  output logic    keyDone
);
  logic [CNT_W-1:0] stepCnt;
  logic             reverseQ;
  logic             atEnd;
  int unsigned      roundIdx;

  assign atEnd = (stepCnt == CNT_W'(ROUNDS));

  always_comb begin
    roundIdx = reverseQ ? (ROUNDS - int'(stepCnt)) : (int'(stepCnt) + 1);
    ctl.load      = loadKey;
    ctl.advance   = stepKey && !loadKey && !atEnd;
    ctl.reverse   = reverseQ;
    ctl.twoPlaces = !singleShift(roundIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt  <= '0;
      reverseQ <= 1'b0;
    end else if (loadKey) begin
      stepCnt  <= '0;
      reverseQ <= dirIn;
    end else if (ctl.advance) begin
      stepCnt  <= stepCnt + 1'b1;
    end
  end

  assign keyDone = atEnd;
endmodule

// File: rtl/des_keygen_dp.sv
module des_keygen_dp
  import des_keygen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  keyCtl_t          ctl,
  input  logic [KEY_W-1:0] keyIn,
  output logic [SUB_W-1:0] subKey
);
  logic [HALF_W-1:0] cHalf, dHalf;
  logic [HALF_W-1:0] cNext, dNext;

  always_comb begin
    cNext = rotHalf(cHalf, ctl.twoPlaces, ctl.reverse);
    dNext = rotHalf(dHalf, ctl.twoPlaces, ctl.reverse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cHalf  <= '0;
      dHalf  <= '0;
      subKey <= '0;
    end else if (ctl.load) begin
      {cHalf, dHalf} <= reduceKey(keyIn);
      subKey         <= '0;
    end else if (ctl.advance) begin
      cHalf  <= cNext;
      dHalf  <= dNext;
      subKey <= ctl.reverse ? compressKey({cHalf, dHalf})
                            : compressKey({cNext, dNext});
    end
  end
endmodule

// File: rtl/des_keygen.sv
module des_keygen
  import des_keygen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadKey,
  input  logic        stepKey,
  input  logic        dirIn,
  input  logic [63:0] keyIn,
  output logic [47:0] subKey,
  output logic        keyDone
);
  keyCtl_t ctl;

  des_keygen_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadKey(loadKey), .stepKey(stepKey),
    .dirIn(dirIn), .ctl(ctl), .keyDone(keyDone)
  );

  des_keygen_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .keyIn(keyIn), .subKey(subKey)
  );
endmodule

// File: rtl/des_keygen_chk.sv
module des_keygen_chk
  import des_keygen_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        loadKey,
  input logic        stepKey,
  input logic [47:0] subKey,
  input logic        keyDone
);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    seen <= '0;
    else if (loadKey)                              seen <= '0;
    else if (stepKey && seen != CNT_W'(ROUNDS))    seen <= seen + 1'b1;
  end

  // R5: done tracks the independent count of accepted steps
  a_r5_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    keyDone == (seen == CNT_W'(ROUNDS)));

  // R7
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    loadKey |=> (subKey == '0) && !keyDone);

  // R6
  a_r6_step_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (keyDone && stepKey && !loadKey) |=> $stable(subKey) && keyDone);

  // R4
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stepKey && !loadKey) |=> $stable(subKey) && $stable(keyDone));

  // R5: done rises only on an accepted step
  a_r5_rise_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keyDone) |-> $past(stepKey) && !$past(loadKey));
endmodule

bind des_keygen des_keygen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loadKey(loadKey), .stepKey(stepKey),
  .subKey(subKey), .keyDone(keyDone)
);

// File: tb/sim_des_keygen.sv
module sim_des_keygen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadKey = 1'b0;
  logic        stepKey = 1'b0;
  logic        dirIn = 1'b0;
  logic [63:0] keyIn = '0;
  logic [47:0] subKey;
  logic        keyDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  des_keygen u0 (.clk(clk), .rst_n(rst_n), .loadKey(loadKey), .stepKey(stepKey),
                 .dirIn(dirIn), .keyIn(keyIn), .subKey(subKey), .keyDone(keyDone));

  int t56 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                   10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                   63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                   14,6,61,53,45,37,29,21,13,5,28,20,12,4};
  int t48 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                   23,19,12,4,26,8,16,7,27,20,13,2,
                   41,52,31,37,47,55,30,40,51,45,33,48,
                   44,49,39,56,34,53,46,42,50,36,29,32};

  // Forward round key idx (1..16) computed from the requirements
  function automatic logic [47:0] refKey(input logic [63:0] k, input int idx);
    logic [55:0] cd;
    logic [27:0] c, d;
    logic [47:0] o;
    for (int i = 0; i < 56; i++) cd[55-i] = k[64-t56[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 1; r <= idx; r++) begin
      int n = (r == 1 || r == 2 || r == 9 || r == 16) ? 1 : 2;
      for (int s = 0; s < n; s++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
    end
    cd = {c, d};
    for (int i = 0; i < 48; i++) o[47-i] = cd[56-t48[i]];
    return o;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [63:0] k, input logic dir);
    @(negedge clk);
    loadKey = 1'b1; keyIn = k; dirIn = dir;
    @(negedge clk);
    loadKey = 1'b0;
  endtask

  task automatic doStep();
    @(negedge clk);
    stepKey = 1'b1;
    @(negedge clk);
    stepKey = 1'b0;
  endtask

  task automatic testReset();
    chk("R10 subKey", subKey, 48'h0);
    chk("R10 keyDone", {47'h0, keyDone}, 48'h0);
  endtask

  task automatic testKnown();
    doLoad(64'h133457799BBCDFF1, 1'b0);
    chk("R7 cleared after load", subKey, 48'h0);
    doStep();
    chk("R1 known first key", subKey, 48'h1B02EFFC7072);
  endtask

  task automatic testForward(input logic [63:0] k);
    doLoad(k, 1'b0);
    for (int i = 1; i <= 16; i++) begin
      chk("R5 done before end", {47'h0, keyDone}, 48'h0);
      doStep();
      chk("R2 forward key", subKey, refKey(k, i));
    end
    chk("R5 done at end", {47'h0, keyDone}, 48'h1);
  endtask

  task automatic testReverse(input logic [63:0] k);
    doLoad(k, 1'b1);
    for (int i = 16; i >= 1; i--) begin
      doStep();
      chk("R3 reverse key", subKey, refKey(k, i));
    end
    chk("R5 done reverse", {47'h0, keyDone}, 48'h1);
  endtask

  task automatic testOverrun();
    logic [47:0] last;
    last = subKey;
    doStep();
    doStep();
    chk("R6 key unchanged", subKey, last);
    chk("R6 done held", {47'h0, keyDone}, 48'h1);
  endtask

  task automatic testGap(input logic [63:0] k);
    doLoad(k, 1'b0);
    doStep();
    repeat (3) @(negedge clk);
    chk("R4 hold during gap", subKey, refKey(k, 1));
    doStep();
    chk("R4 next after gap", subKey, refKey(k, 2));
  endtask

  task automatic testDirLatch(input logic [63:0] k);
    doLoad(k, 1'b0);
    dirIn = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      doStep();
      chk("R8 dir ignored", subKey, refKey(k, i));
    end
    dirIn = 1'b0;
  endtask

  task automatic testLoadPriority(input logic [63:0] k);
    doLoad(k, 1'b0);
    doStep();
    doStep();
    @(negedge clk);
    loadKey = 1'b1; stepKey = 1'b1; keyIn = k; dirIn = 1'b0;
    @(negedge clk);
    loadKey = 1'b0; stepKey = 1'b0;
    chk("R7 load beats step key", subKey, 48'h0);
    chk("R7 load beats step done", {47'h0, keyDone}, 48'h0);
    doStep();
    chk("R7 restart at first", subKey, refKey(k, 1));
  endtask

  task automatic testParity(input logic [63:0] k);
    logic [63:0] k2;
    k2 = k ^ 64'h0101010101010101;
    doLoad(k2, 1'b0);
    for (int i = 1; i <= 16; i++) begin
      doStep();
      chk("R9 parity ignored", subKey, refKey(k, i));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testKnown();
    testForward(64'h133457799BBCDFF1);
    testOverrun();
    testReverse(64'h133457799BBCDFF1);
    testOverrun();
    testForward(64'h0123456789ABCDEF);
    testReverse(64'hFEDCBA9876543210);
    testReverse(64'h8000000000000001);
    testGap(64'hA5A5C3C30F0FF00F);
    testDirLatch(64'h1122334455667788);
    testLoadPriority(64'hDEADBEEFCAFEF00D);
    testParity(64'h0E329232EA6D0D73);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule